// File: doc/BRIEF.md
# Embedded Register Line Formatter

This block produces the register-snapshot lines that precede the image rows in a 12-bit parallel pixel stream. A single-cycle start pulse selects one of two line layouts. The block then walks a fixed register address range, reads each 16-bit register through a combinational read port, and turns the result into a stream of 12-bit words.

Every byte leaves in the upper eight bits of a word, and the lower four bits are zero. A line opens with a format tag. Next comes the start address, in which each address byte follows its own marker word. After that, every register value byte follows a value marker, high byte first. Registers that the read port reports as undefined are sent as zero.

The first line layout covers one contiguous range. The second layout covers two ranges. A configuration input sets how the hole between those two ranges is handled:
- In split mode, a fresh address header is emitted at the second range.
- In continuous mode, the walk runs straight through the hole and sends zero values for it.

Output words use a valid/ready handshake. A one-cycle done pulse follows acceptance of the final word.

Top module: `emb_reg_line_fmt`

## Requirements
- R1: The first word of every line is 0x0A0 (format code 0x0A placed in bits [11:4]).
- R2: Every byte sits in bits [11:4] of its word with bits [3:0] zero. A 16-bit value is sent high byte first, so 0x1234 becomes 0x120 and then 0x340.
- R3: Each address header is the sequence 0xAA0, {addr[15:8],0}, 0xA50, {addr[7:0],0}. It appears once per range segment, directly after the tag or after the previous segment's last value.
- R4: Every value byte is preceded by the marker 0x5A0. Successive values belong to addresses increasing by 2 from the header address.
- R5: With line select 0, the line covers 0x3000 through 0x312E, which is 152 registers and 613 words in total.
- R6: With line select 1 and split mode 1, the line covers 0x3136 through 0x31BE, then a new header with 0x31D0, then through 0x31FE. That is 381 words.
- R7: With line select 1 and split mode 0, a single header at 0x3136 is followed by all even addresses up to 0x31FE. That is 409 words. Addresses 0x31C0 to 0x31CE are sent as value 0 whatever the read port returns.
- R8: When the register defined flag is low for the addressed register, its value is sent as 0x0000.
- R9: While valid is high and ready is low, valid stays high and the output word does not change.
- R10: Done is high for exactly one cycle: the cycle after the handshake of the last word. It is never high at any other time.
- R11: A start pulse that arrives while a line is being produced or is still pending at the output is ignored. No extra words follow that line.
- R12: After reset, valid and done are low, and no words appear until a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin one embedded line |
| line_sel_i | input | 1 | 0: first layout, 1: second layout (sampled at start) |
| split_i | input | 1 | Second layout: 1 re-headers at the second range, 0 walks through the hole |
| reg_addr_o | output | 16 | Register read address |
| reg_data_i | input | 16 | Register read data for reg_addr_o (same cycle) |
| reg_hit_i | input | 1 | High when reg_addr_o names a defined register |
| pix_o | output | 12 | Output word |
| pix_valid_o | output | 1 | Output word valid |
| pix_ready_i | input | 1 | Downstream accepts the word |
| line_done_o | output | 1 | One-cycle pulse after the last word is accepted |

## Verification
A start request can land in the same cycle as the output stage still holding a word under back-pressure, or in the same cycle as the done pulse. The bench provokes this by pulsing start in the middle of a line whose ready input follows an irregular stall pattern. It then judges the outcome at the ports: the stream must match the single expected line word for word, done must pulse exactly once, and valid must stay low afterwards. A second overlap is a ready stall on the last value word of a segment, in the same cycle as the jump to the next header. Split-mode runs under stall patterns check that this word is held and that the header follows it without a gap or a duplicate.

// File: rtl/emb_line_pkg.sv
`timescale 1ns/1ps
package emb_line_pkg;
  localparam int PIX_W  = 12;
  localparam int BYTE_W = 8;
  localparam int PAD_W  = PIX_W - BYTE_W;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_TAG, PH_MRK_AH, PH_ADR_H, PH_MRK_AL, PH_ADR_L,
    PH_MRK_VH, PH_VAL_H, PH_MRK_VL, PH_VAL_L
  } phase_t;

  localparam byte_t CODE_TAG  = 8'h0A;
  localparam byte_t CODE_AHI  = 8'hAA;
  localparam byte_t CODE_ALO  = 8'hA5;
  localparam byte_t CODE_VAL  = 8'h5A;
  localparam int    REG_STEP  = 2;

  function automatic pix_t msb_align(input byte_t b);
    return {b, {PAD_W{1'b0}}};
  endfunction

  function automatic addr_t next_reg(input addr_t a);
    return a + addr_t'(REG_STEP);
  endfunction

  function automatic logic strictly_between(input addr_t a, input addr_t lo, input addr_t hi);
    return (a > lo) && (a < hi);
  endfunction

  function automatic pix_t word_for(input phase_t ph, input addr_t a, input data_t v);
    pix_t w;
    case (ph)
      PH_TAG:                w = msb_align(CODE_TAG);
      PH_MRK_AH:             w = msb_align(CODE_AHI);
      PH_ADR_H:              w = msb_align(a[15:8]);
      PH_MRK_AL:             w = msb_align(CODE_ALO);
      PH_ADR_L:              w = msb_align(a[7:0]);
      PH_MRK_VH, PH_MRK_VL:  w = msb_align(CODE_VAL);
      PH_VAL_H:              w = msb_align(v[15:8]);
      PH_VAL_L:              w = msb_align(v[7:0]);
      default:               w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/emb_addr_walker.sv
`timescale 1ns/1ps
module emb_addr_walker
  import emb_line_pkg::*;
#(
  parameter addr_t L1_FIRST  = 16'h3000,
  parameter addr_t L1_LAST   = 16'h312E,
  parameter addr_t L2A_FIRST = 16'h3136,
  parameter addr_t L2A_LAST  = 16'h31BE,
  parameter addr_t L2B_FIRST = 16'h31D0,
  parameter addr_t L2B_LAST  = 16'h31FE
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  line_sel_i,
  input  logic  split_i,
  input  logic  step_reg_i,
  input  logic  step_seg_i,
  output addr_t addr_o,
  output logic  seg_last_o,
  output logic  more_seg_o,
  output logic  gap_o
);
  logic  line_q, split_q, seg_q;
  addr_t addr_q;
  addr_t seg_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      split_q <= 1'b0;
      seg_q   <= 1'b0;
      addr_q  <= L1_FIRST;
    end else if (load_i) begin
      line_q  <= line_sel_i;
      split_q <= split_i;
      seg_q   <= 1'b0;
      addr_q  <= line_sel_i ? L2A_FIRST : L1_FIRST;
    end else if (step_seg_i) begin
      seg_q   <= 1'b1;
      addr_q  <= L2B_FIRST;
    end else if (step_reg_i) begin
      addr_q  <= next_reg(addr_q);
    end
  end

  always_comb begin
    if (!line_q)                seg_end = L1_LAST;
    else if (split_q && !seg_q) seg_end = L2A_LAST;
    else                        seg_end = L2B_LAST;
  end

  assign addr_o     = addr_q;
  assign seg_last_o = (addr_q == seg_end);
  assign more_seg_o = line_q && split_q && !seg_q;
  assign gap_o      = line_q && !split_q && strictly_between(addr_q, L2A_LAST, L2B_FIRST);

  p_seg_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_seg_i && !load_i |=> (addr_o == L2B_FIRST) && !more_seg_o);
  p_line1_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !line_q |-> (addr_o >= L1_FIRST) && (addr_o <= L1_LAST));
  p_gap_only_cont_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gap_o |-> !more_seg_o && line_q);
endmodule

// File: rtl/emb_field_fsm.sv
`timescale 1ns/1ps
module emb_field_fsm
  import emb_line_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   pending_i,
  input  logic   take_i,
  input  logic   seg_last_i,
  input  logic   more_seg_i,
  output phase_t phase_o,
  output logic   load_o,
  output logic   adv_o,
  output logic   step_reg_o,
  output logic   step_seg_o,
  output logic   last_o
);
  phase_t phase_q, phase_d;

  assign load_o = (phase_q == PH_IDLE) && start_i && !pending_i;
  assign adv_o  = (phase_q != PH_IDLE) && take_i;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (load_o) phase_d = PH_TAG;
      PH_TAG:    if (adv_o)  phase_d = PH_MRK_AH;
      PH_MRK_AH: if (adv_o)  phase_d = PH_ADR_H;
      PH_ADR_H:  if (adv_o)  phase_d = PH_MRK_AL;
      PH_MRK_AL: if (adv_o)  phase_d = PH_ADR_L;
      PH_ADR_L:  if (adv_o)  phase_d = PH_MRK_VH;
      PH_MRK_VH: if (adv_o)  phase_d = PH_VAL_H;
      PH_VAL_H:  if (adv_o)  phase_d = PH_MRK_VL;
      PH_MRK_VL: if (adv_o)  phase_d = PH_VAL_L;
      PH_VAL_L:  if (adv_o) begin
        if (!seg_last_i)     phase_d = PH_MRK_VH;
        else if (more_seg_i) phase_d = PH_MRK_AH;
        else                 phase_d = PH_IDLE;
      end
      default:               phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase_o    = phase_q;
  assign step_reg_o = adv_o && (phase_q == PH_VAL_L) && !seg_last_i;
  assign step_seg_o = adv_o && (phase_q == PH_VAL_L) && seg_last_i && more_seg_i;
  assign last_o     = (phase_q == PH_VAL_L) && seg_last_i && !more_seg_i;

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) && start_i |=> phase_q != PH_TAG);
  p_pending_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pending_i && (phase_q == PH_IDLE) |=> phase_q == PH_IDLE);
endmodule

// File: rtl/emb_pix_out.sv
`timescale 1ns/1ps
module emb_pix_out
  import emb_line_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  pix_t word_i,
  input  logic last_i,
  input  logic ready_i,
  output logic take_o,
  output logic pending_o,
  output pix_t pix_o,
  output logic valid_o,
  output logic done_o
);
  pix_t pix_q;
  logic valid_q, last_q, done_q;

  assign take_o = !valid_q || ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= valid_q && ready_i && last_q;
      if (load_i) begin
        pix_q   <= word_i;
        valid_q <= 1'b1;
        last_q  <= last_i;
      end else if (ready_i) begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end
    end
  end

  assign pix_o     = pix_q;
  assign valid_o   = valid_q;
  assign done_o    = done_q;
  assign pending_o = valid_q || done_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(pix_o));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);
endmodule

// File: rtl/emb_reg_line_fmt.sv
`timescale 1ns/1ps
module emb_reg_line_fmt
  import emb_line_pkg::*;
#(
  parameter addr_t L1_FIRST  = 16'h3000,
  parameter addr_t L1_LAST   = 16'h312E,
  parameter addr_t L2A_FIRST = 16'h3136,
  parameter addr_t L2A_LAST  = 16'h31BE,
  parameter addr_t L2B_FIRST = 16'h31D0,
  parameter addr_t L2B_LAST  = 16'h31FE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        line_sel_i,
  input  logic        split_i,
  output logic [15:0] reg_addr_o,
  input  logic [15:0] reg_data_i,
  input  logic        reg_hit_i,
  output logic [11:0] pix_o,
  output logic        pix_valid_o,
  input  logic        pix_ready_i,
  output logic        line_done_o
);
  phase_t phase;
  addr_t  cur_addr;
  data_t  reg_val;
  pix_t   next_word;
  logic   ev_load, ev_adv, ev_step_reg, ev_step_seg, ev_last;
  logic   seg_last, more_seg, in_gap, out_take, out_pending;

  emb_addr_walker #(
    .L1_FIRST(L1_FIRST), .L1_LAST(L1_LAST),
    .L2A_FIRST(L2A_FIRST), .L2A_LAST(L2A_LAST),
    .L2B_FIRST(L2B_FIRST), .L2B_LAST(L2B_LAST)
  ) walker_i (
    .clk(clk), .rst_n(rst_n), .load_i(ev_load), .line_sel_i(line_sel_i),
    .split_i(split_i), .step_reg_i(ev_step_reg), .step_seg_i(ev_step_seg),
    .addr_o(cur_addr), .seg_last_o(seg_last), .more_seg_o(more_seg), .gap_o(in_gap)
  );

  emb_field_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pending_i(out_pending),
    .take_i(out_take), .seg_last_i(seg_last), .more_seg_i(more_seg),
    .phase_o(phase), .load_o(ev_load), .adv_o(ev_adv),
    .step_reg_o(ev_step_reg), .step_seg_o(ev_step_seg), .last_o(ev_last)
  );

  assign reg_val   = (reg_hit_i && !in_gap) ? reg_data_i : '0;
  assign next_word = word_for(phase, cur_addr, reg_val);

  emb_pix_out out_i (
    .clk(clk), .rst_n(rst_n), .load_i(ev_adv), .word_i(next_word), .last_i(ev_last),
    .ready_i(pix_ready_i), .take_o(out_take), .pending_o(out_pending),
    .pix_o(pix_o), .valid_o(pix_valid_o), .done_o(line_done_o)
  );

  assign reg_addr_o = cur_addr;

  p_tag_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid_o) |-> pix_o == msb_align(CODE_TAG));
  p_low_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> pix_o[PAD_W-1:0] == '0);
  p_gap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_adv && in_gap && (phase == PH_VAL_H) |=> pix_o == '0);
  p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_adv && !reg_hit_i && (phase == PH_VAL_L) |=> pix_o == '0);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) && !pix_valid_o |=> !pix_valid_o);
endmodule

// File: tb/emb_reg_line_fmt_tb.sv
`timescale 1ns/1ps
module emb_reg_line_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, line_sel = 1'b0, split = 1'b0, ready = 1'b0;
  logic [15:0] reg_addr, reg_data;
  logic        reg_hit;
  logic [11:0] pix;
  logic        valid, done;
  int          n_checks = 0, n_errors = 0;
  int          cycles = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  emb_reg_line_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .line_sel_i(line_sel), .split_i(split),
    .reg_addr_o(reg_addr), .reg_data_i(reg_data), .reg_hit_i(reg_hit),
    .pix_o(pix), .pix_valid_o(valid), .pix_ready_i(ready), .line_done_o(done)
  );

  function automatic logic [15:0] model_val(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h9C35;
  endfunction
  function automatic logic model_def(input logic [15:0] a);
    return a[3:1] != 3'd5;
  endfunction
  assign reg_data = model_val(reg_addr);
  assign reg_hit  = model_def(reg_addr);

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [11:0] hi8(input logic [7:0] b);
    return {b, 4'h0};
  endfunction

  task automatic push_seg(input logic [15:0] lo, input logic [15:0] hi, input logic zero_hole);
    exp_q.push_back(12'hAA0); tag_q.push_back("R3");
    exp_q.push_back(hi8(lo[15:8])); tag_q.push_back("R3");
    exp_q.push_back(12'hA50); tag_q.push_back("R3");
    exp_q.push_back(hi8(lo[7:0])); tag_q.push_back("R3");
    for (int a = lo; a <= hi; a += 2) begin
      logic [15:0] v;
      v = model_def(16'(a)) ? model_val(16'(a)) : 16'h0;
      if (zero_hole && a >= 'h31C0 && a <= 'h31CE) v = 16'h0;
      exp_q.push_back(12'h5A0); tag_q.push_back("R4");
      exp_q.push_back(hi8(v[15:8])); tag_q.push_back(model_def(16'(a)) ? "R2" : "R8");
      exp_q.push_back(12'h5A0); tag_q.push_back("R4");
      exp_q.push_back(hi8(v[7:0])); tag_q.push_back(zero_hole ? "R7" : "R2");
    end
  endtask

  task automatic build(input logic l, input logic s);
    exp_q.delete(); tag_q.delete();
    exp_q.push_back(12'h0A0); tag_q.push_back("R1");
    if (!l) push_seg(16'h3000, 16'h312E, 1'b0);
    else if (s) begin
      push_seg(16'h3136, 16'h31BE, 1'b0);
      push_seg(16'h31D0, 16'h31FE, 1'b0);
    end else push_seg(16'h3136, 16'h31FE, 1'b1);
  endtask

  task automatic run_line(input logic l, input logic s, input int stall, input logic poke,
                          input int n_exp, input string req);
    int got = 0, guard = 0;
    logic pv = 0, pr = 0;
    logic [11:0] pp = 0;
    build(l, s);
    chk(exp_q.size() == n_exp, req, exp_q.size(), n_exp);
    @(negedge clk); line_sel = l; split = s; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (got < exp_q.size() && guard < 20000) begin
      if (pv && !pr) chk(valid && pix == pp, "R9", pix, pp);
      case (stall)
        0: ready = 1'b1;
        1: ready = ((guard * 7) % 5) >= 2;
        default: ready = (guard % 4) == 3;
      endcase
      start = poke && (guard == 40 || guard == 300);
      if (poke) line_sel = ~l;
      if (done) chk(1'b0, "R10", 1, 0);
      if (valid && ready) begin
        chk(pix == exp_q[got], tag_q[got], pix, exp_q[got]);
        got++;
      end
      pv = valid; pr = ready; pp = pix;
      @(negedge clk); guard++;
    end
    start = 1'b0;
    chk(got == n_exp, req, got, n_exp);
    chk(done == 1'b1, "R10", done, 1);
    ready = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R10", done, 0);
    for (int i = 0; i < 20; i++) begin
      chk(!valid && !done, "R11", valid, 0);
      @(negedge clk);
    end
    ready = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ready = 1'b1;
      chk(!valid && !done, "R12", {valid, done}, 0);
    end
    ready = 1'b0;
  endtask

  task automatic t_line1;       run_line(1'b0, 1'b0, 0, 1'b0, 613, "R5"); endtask
  task automatic t_line1_stall; run_line(1'b0, 1'b1, 1, 1'b0, 613, "R5"); endtask
  task automatic t_line2_split; run_line(1'b1, 1'b1, 1, 1'b0, 381, "R6"); endtask
  task automatic t_line2_cont;  run_line(1'b1, 1'b0, 2, 1'b0, 409, "R7"); endtask
  task automatic t_ignore_start; run_line(1'b0, 1'b0, 1, 1'b1, 613, "R11"); endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_errors++;
        $display("FAIL R10 watchdog actual=hung expected=line_done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!valid && !done, "R12", {valid, done}, 0);
    rst_n = 1'b1;
    t_reset();
    t_line1();
    t_line1_stall();
    t_line2_split();
    t_line2_cont();
    t_ignore_start();
    t_line2_split();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule